// File: doc/BRIEF.md
# Duty-Dependent Digit-to-Segment-Memory Mapper

This block holds the bit image of a segment-type LCD panel, organised as 4 common rows by 51 segment columns, and applies two kinds of write to it. A digit write carries a digit index and an 8-bit pattern. The block scatters that pattern over a small group of cells, and the shape of the group follows the selected digit layout mode: one row of eight columns, two rows of four, three rows of three, or four rows of two. A single-cell write carries a segment index, a common index and one data bit. It sets exactly that cell, whatever layout mode is selected.

Writes arrive on a valid/ready port. The block accepts one write per clock. `in_ready` is low only while reset is applied, so there is no back-pressure in normal operation. A write whose `in_valid` is sampled high together with `in_ready` changes the memory at that clock edge. The drive-timing logic reads back one whole row at a time through a combinational read port selected by a common index.

Top module: `lcd_digit_mapper`

## Requirements
- R1: While `rst_n` is low, `in_ready` is 0. After reset every cell reads back 0.
- R2: With `disp_mode`=0 (one row), digit n covers columns 8n..8n+7 of row 0. Pattern bit 7 lands in column 8n and bit 0 lands in column 8n+7.
- R3: With `disp_mode`=1 (two rows), digit n covers columns 4n..4n+3 of rows 0 and 1. Pattern bit 7-k lands in column 4n+k/2 and row k%2.
- R4: With `disp_mode`=2 (three rows), digit n covers columns 3n..3n+2 of rows 0 to 2. Pattern bit 7-k lands in column 3n+k/3 and row k%3. The cell at column 3n+2, row 2 is never changed by a digit write.
- R5: With `disp_mode`=3 (four rows), digit n covers columns 2n and 2n+1 of rows 0 to 3. Pattern bit 7-k lands in column 2n+k/4 and row k%4.
- R6: For the last digit of a mode (6, 12, 16 or 25), pattern bits that map beyond column 50 are dropped, and the remaining bits are still written.
- R7: A digit write whose index is above the last digit of its mode changes no cell.
- R8: A single-cell write (`in_kind`=1) updates only cell (`bit_com`, `bit_seg`) with `bit_val`, in every layout mode. A segment index above 50 changes no cell.
- R9: An accepted write is visible on `rd_row` right after the clock edge that accepts it. Cycles with `in_valid` low change nothing, whatever the other inputs carry.
- R10: After reset `in_ready` stays 1, and every write offered is accepted in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A write is offered |
| in_ready | output | 1 | The block can accept a write (low only during reset) |
| in_kind | input | 1 | 0 = digit write, 1 = single-cell write |
| disp_mode | input | 2 | Digit layout: 0 one row, 1 two rows, 2 three rows, 3 four rows |
| dig_addr | input | 5 | Digit index |
| pattern | input | 8 | Digit pattern |
| bit_seg | input | 6 | Segment index for a single-cell write |
| bit_com | input | 2 | Common index for a single-cell write |
| bit_val | input | 1 | Data for a single-cell write |
| rd_com | input | 2 | Row selected for read-back |
| rd_row | output | 51 | Contents of the selected row, column 0 in bit 0 |

## Verification
The hardest case to reach is the three-row cell that digit writes must never touch. A zero pattern only shows that cell is protected if the cell already holds 1, and no digit write can set it. The stimulus therefore first fills the whole memory with ones through single-cell writes. It then runs zero-pattern digit writes over every three-row digit index and reads back row 2 at every third column. After that, every mode is swept over all 32 digit indices with a pattern and then its complement. This covers the clipped last digits and the out-of-range indices in both polarities.

// File: rtl/lcdmap_pkg.sv
package lcdmap_pkg;

  localparam int DIGIT_BITS = 8;
  localparam int MODE_COUNT = 4;

  typedef enum logic [1:0] {
    LAYOUT_ONE_ROW   = 2'd0,
    LAYOUT_TWO_ROW   = 2'd1,
    LAYOUT_THREE_ROW = 2'd2,
    LAYOUT_FOUR_ROW  = 2'd3
  } layout_e;

  typedef enum logic {
    OP_DIGIT = 1'b0,
    OP_CELL  = 1'b1
  } op_kind_e;

  // rows used by a digit group in layout m
  function automatic int layout_rows(int m);
    return m + 1;
  endfunction

  // columns used by a digit group in layout m
  function automatic int layout_cols(int m);
    case (m)
      0:       return 8;
      1:       return 4;
      2:       return 3;
      default: return 2;
    endcase
  endfunction

  // highest digit index whose group starts inside the column range
  function automatic int layout_last(int m, int nseg);
    int w;
    w = layout_cols(m);
    return (nseg + w - 1) / w - 1;
  endfunction

endpackage

// File: rtl/lcdmap_digit_scatter.sv
module lcdmap_digit_scatter #(
  parameter int NSEG   = 51,
  parameter int NCOM   = 4,
  parameter int ADDR_W = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  lcdmap_pkg::layout_e             mode,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [lcdmap_pkg::DIGIT_BITS-1:0] pattern,
  output logic [NCOM-1:0][NSEG-1:0]       wr_mask,
  output logic [NCOM-1:0][NSEG-1:0]       wr_data
);
  import lcdmap_pkg::*;

  localparam int SEG_W = $clog2(NSEG);
  localparam int COM_W = $clog2(NCOM);
  localparam int BIT_W = $clog2(DIGIT_BITS);

  function automatic logic [NSEG-1:0] third_corner_cells();
    logic [NSEG-1:0] r;
    r = '0;
    for (int s = 0; s < NSEG; s++) r[s] = ((s % 3) == 2);
    return r;
  endfunction

  localparam logic [NSEG-1:0] CORNER = third_corner_cells();

  logic [MODE_COUNT-1:0][NCOM-1:0][NSEG-1:0] mode_mask;
  logic [MODE_COUNT-1:0][NCOM-1:0][NSEG-1:0] mode_data;

  for (genvar m = 0; m < MODE_COUNT; m++) begin : g_layout
    localparam int ROWS = layout_rows(m);
    localparam int COLS = layout_cols(m);
    localparam int LAST = layout_last(m, NSEG);

    always_comb begin
      int col;
      mode_mask[m] = '0;
      mode_data[m] = '0;
      col = 0;
      if (int'(addr) <= LAST) begin
        for (int k = 0; k < DIGIT_BITS; k++) begin
          col = int'(addr) * COLS + k / ROWS;
          if (col < NSEG) begin
            mode_mask[m][COM_W'(k % ROWS)][SEG_W'(col)] = 1'b1;
            mode_data[m][COM_W'(k % ROWS)][SEG_W'(col)] =
              pattern[BIT_W'(DIGIT_BITS - 1 - k)];
          end
        end
      end
    end
  end

  always_comb begin
    wr_mask = '0;
    wr_data = '0;
    if (en) begin
      wr_mask = mode_mask[mode];
      wr_data = mode_data[mode];
    end
  end

  // R2: a digit never touches more cells than it has pattern bits
  assert_digit_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_mask) <= DIGIT_BITS);

  // R4: the corner cell of a three-row group is unreachable by a digit
  assert_corner_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LAYOUT_THREE_ROW) |-> ((wr_mask[2] & CORNER) == '0));

  // R5: only the four-row layout reaches the last row
  assert_row3_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != LAYOUT_FOUR_ROW) |-> (wr_mask[NCOM-1] == '0));

  // R7: digit index beyond the four-row range never writes
  assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) > layout_last(3, NSEG)) |-> (wr_mask == '0));

endmodule

// File: rtl/lcdmap_cell_select.sv
module lcdmap_cell_select #(
  parameter int NSEG  = 51,
  parameter int NCOM  = 4,
  parameter int SEG_W = 6,
  parameter int COM_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [SEG_W-1:0]          seg,
  input  logic [COM_W-1:0]          com,
  input  logic                      val,
  output logic [NCOM-1:0][NSEG-1:0] wr_mask,
  output logic [NCOM-1:0][NSEG-1:0] wr_data
);

  logic in_range;
  assign in_range = (int'(seg) < NSEG) && (int'(com) < NCOM);

  always_comb begin
    wr_mask = '0;
    wr_data = '0;
    if (en && in_range) begin
      wr_mask[com][seg] = 1'b1;
      wr_data[com][seg] = val;
    end
  end

  // R8: a single-cell write selects at most one cell
  assert_one_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_mask));

  // R8: an out-of-range segment selects nothing
  assert_seg_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(seg) >= NSEG) |-> (wr_mask == '0));

endmodule

// File: rtl/lcdmap_cell_store.sv
module lcdmap_cell_store #(
  parameter int NSEG  = 51,
  parameter int NCOM  = 4,
  parameter int COM_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCOM-1:0][NSEG-1:0] wr_mask,
  input  logic [NCOM-1:0][NSEG-1:0] wr_data,
  input  logic [COM_W-1:0]          rd_com,
  output logic [NSEG-1:0]           rd_row
);

  logic [NCOM-1:0][NSEG-1:0] cells_q;

  for (genvar r = 0; r < NCOM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) cells_q[r] <= '0;
      else        cells_q[r] <= (cells_q[r] & ~wr_mask[r]) | (wr_data[r] & wr_mask[r]);
    end

    // R9: written cells take the new data one edge later
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((cells_q[r] ^ $past(wr_data[r])) & $past(wr_mask[r])) == '0));

    // R9: unselected cells hold their value
    assert_others_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((cells_q[r] ^ $past(cells_q[r])) & ~$past(wr_mask[r])) == '0));
  end

  always_comb begin
    rd_row = '0;
    if (int'(rd_com) < NCOM) rd_row = cells_q[rd_com];
  end

endmodule

// File: rtl/lcd_digit_mapper.sv
module lcd_digit_mapper #(
  parameter int NSEG   = 51,
  parameter int NCOM   = 4,
  parameter int SEG_W  = $clog2(NSEG),
  parameter int COM_W  = $clog2(NCOM),
  parameter int ADDR_W = $clog2(lcdmap_pkg::layout_last(3, NSEG) + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic                             in_kind,
  input  logic [1:0]                       disp_mode,
  input  logic [ADDR_W-1:0]                dig_addr,
  input  logic [lcdmap_pkg::DIGIT_BITS-1:0] pattern,
  input  logic [SEG_W-1:0]                 bit_seg,
  input  logic [COM_W-1:0]                 bit_com,
  input  logic                             bit_val,
  input  logic [COM_W-1:0]                 rd_com,
  output logic [NSEG-1:0]                  rd_row
);
  import lcdmap_pkg::*;

  logic                      ready_q;
  logic                      accept;
  logic                      digit_en;
  logic                      cell_en;
  layout_e                   layout;
  logic [NCOM-1:0][NSEG-1:0] dig_mask, dig_data;
  logic [NCOM-1:0][NSEG-1:0] cel_mask, cel_data;
  logic [NCOM-1:0][NSEG-1:0] wr_mask, wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;
  assign digit_en = accept && (op_kind_e'(in_kind) == OP_DIGIT);
  assign cell_en  = accept && (op_kind_e'(in_kind) == OP_CELL);
  assign layout   = layout_e'(disp_mode);

  lcdmap_digit_scatter #(.NSEG(NSEG), .NCOM(NCOM), .ADDR_W(ADDR_W)) u_scatter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (digit_en),
    .mode    (layout),
    .addr    (dig_addr),
    .pattern (pattern),
    .wr_mask (dig_mask),
    .wr_data (dig_data)
  );

  lcdmap_cell_select #(.NSEG(NSEG), .NCOM(NCOM), .SEG_W(SEG_W), .COM_W(COM_W)) u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cell_en),
    .seg     (bit_seg),
    .com     (bit_com),
    .val     (bit_val),
    .wr_mask (cel_mask),
    .wr_data (cel_data)
  );

  assign wr_mask = dig_mask | cel_mask;
  assign wr_data = dig_data | cel_data;

  lcdmap_cell_store #(.NSEG(NSEG), .NCOM(NCOM), .COM_W(COM_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .rd_com  (rd_com),
    .rd_row  (rd_row)
  );

  // R10: once ready, the port never pushes back
  assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R9: idle cycles write nothing
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (wr_mask == '0));

  // R8: a single-cell write never uses the digit path
  assert_cell_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind) |-> (dig_mask == '0));

endmodule

// File: tb/test_lcd_digit_mapper.sv
`timescale 1ns/100ps
module test_lcd_digit_mapper;

  localparam int NSEG = 51;
  localparam int NCOM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_kind = 1'b0;
  logic [1:0]  disp_mode = 2'd0;
  logic [4:0]  dig_addr = '0;
  logic [7:0]  pattern = '0;
  logic [5:0]  bit_seg = '0;
  logic [1:0]  bit_com = '0;
  logic        bit_val = 1'b0;
  logic [1:0]  rd_com = '0;
  logic [NSEG-1:0] rd_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [NSEG-1:0] exp_rows [NCOM];

  always #2 clk = ~clk;

  lcd_digit_mapper i_lcd_digit_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .disp_mode(disp_mode), .dig_addr(dig_addr),
    .pattern(pattern), .bit_seg(bit_seg), .bit_com(bit_com),
    .bit_val(bit_val), .rd_com(rd_com), .rd_row(rd_row)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_rows(input string tag);
    for (int c = 0; c < NCOM; c++) begin
      rd_com = c[1:0];
      #0.3;
      checks++;
      if (rd_row !== exp_rows[c]) begin
        errors++;
        $display("FAIL %s row %0d: got %h expected %h", tag, c, rd_row, exp_rows[c]);
      end
    end
  endtask

  task automatic model_digit(input int m, input int addr, input logic [7:0] pat);
    int r, w, last, s;
    r = m + 1;
    w = (m == 0) ? 8 : (m == 1) ? 4 : (m == 2) ? 3 : 2;
    last = (NSEG + w - 1) / w - 1;
    if (addr <= last) begin
      for (int k = 0; k < 8; k++) begin
        s = addr * w + k / r;
        if (s < NSEG) exp_rows[k % r][s] = pat[7 - k];
      end
    end
  endtask

  task automatic drive(input logic kind, input int m, input int addr, input logic [7:0] pat,
                       input int seg, input int com, input logic v);
    @(negedge clk);
    check_bit("R10 ready before write", in_ready, 1'b1);
    in_valid = 1'b1; in_kind = kind; disp_mode = m[1:0]; dig_addr = addr[4:0];
    pattern = pat; bit_seg = seg[5:0]; bit_com = com[1:0]; bit_val = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    for (int c = 0; c < NCOM; c++) exp_rows[c] = '0;
    repeat (3) @(negedge clk);
    check_bit("R1 ready low in reset", in_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10 ready after reset", in_ready, 1'b1);
    check_rows("R1 cleared");

    // fill every cell with one through single-cell writes, rotating layouts
    for (int c = 0; c < NCOM; c++) begin
      for (int s = 0; s < 64; s++) begin
        drive(1'b1, (c + s) % 4, 31, 8'h00, s, c, 1'b1);
        if (s < NSEG) exp_rows[c][s] = 1'b1;
        check_rows(s < NSEG ? "R8 cell set" : "R8 segment out of range");
      end
    end

    // clear one cell, visible right after the accepting edge
    drive(1'b1, 2, 0, 8'h00, 17, 3, 1'b0);
    exp_rows[3][17] = 1'b0;
    check_rows("R9 visible next cycle");

    // three-row zero digits must leave corner cells at one
    for (int a = 0; a < 32; a++) begin
      drive(1'b0, 2, a, 8'h00, 0, 0, 1'b0);
      model_digit(2, a, 8'h00);
      check_rows(a > 16 ? "R7 three-row" : "R4 zero digit");
    end
    for (int n = 0; n < 17; n++) begin
      rd_com = 2'd2;
      #0.3;
      check_bit("R4 corner kept", rd_row[3 * n + 2], 1'b1);
    end

    // idle cycles with junk on the inputs
    @(negedge clk);
    in_valid = 1'b0; in_kind = 1'b1; bit_seg = 6'd5; bit_com = 2'd0; bit_val = 1'b0;
    dig_addr = 5'd0; pattern = 8'hFF;
    repeat (3) @(negedge clk);
    check_rows("R9 idle no change");

    // exhaustive digit sweeps, pattern then complement
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 32; a++) begin
          logic [7:0] pat;
          int w, last;
          pat = 8'((a * 37 + m * 11 + 8'h5A) & 8'hFF);
          if (p == 1) pat = ~pat;
          w = (m == 0) ? 8 : (m == 1) ? 4 : (m == 2) ? 3 : 2;
          last = (NSEG + w - 1) / w - 1;
          drive(1'b0, m, a, pat, 0, 0, 1'b0);
          model_digit(m, a, pat);
          if (a == last)     check_rows("R6 last digit clipped");
          else if (a > last) check_rows("R7 index out of range");
          else               check_rows(mode_tag(m));
        end
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule